// File: doc/BRIEF.md
# Acknowledgment Coalescing Tracker

This block guards one special interrupt line that is shared by up to N processors. When the line fires and no acknowledgment is outstanding, the interrupt is delivered. The block then latches the set of processors the delivery reached and counts how many end-of-interrupt acknowledgments it still expects. While that count is above zero, further firings of the line are reported as coalesced and are not delivered. Each processor's acknowledgment removes that processor from the set. The count goes down only when the processor was actually in the set.

A full restore rebuilds the tracking state from two bitmaps: one holds per-processor pending flags, the other marks the processors the line's entry targets. The restore first wipes the state. It then visits the processors in ascending order, one per cycle, and pulses a done flag at the end. The logic that decides which processors a delivery reaches sits outside this block and supplies that set as a bitmap.

Top module: `ack_coalesce_tracker`

## Requirements
- R1: Synchronous active-high reset leaves the destination map at zero, the outstanding count at zero, and the delivered, coalesced, busy, done and error outputs low.
- R2: A line firing while the count is zero and no restore is running produces a one-cycle delivered pulse on the next cycle. In that same cycle the map equals the reach bitmap and the count equals the number of ones in it.
- R3: A line firing while the count is nonzero produces a one-cycle coalesced pulse on the next cycle. There is no delivered pulse, and the map and count are unchanged.
- R4: An acknowledgment carrying processor index i, whose map bit i is set, clears bit i and lowers the count by one on the next cycle.
- R5: An acknowledgment for a processor whose map bit is clear leaves the map and the count unchanged.
- R6: The count always equals the number of set bits in the destination map.
- R7: A restore start clears the map and count on the next cycle and raises busy. Processors 0 to N-1 are then visited on the following N cycles. Busy falls and done pulses for one cycle after the last visit. At that point the map equals pending AND targeted, and the count is its population.
- R8: While busy is high, line firings, acknowledgments and further restore starts are ignored. No delivered or coalesced pulse results.
- R9: The error flag rises, and holds until reset, only if an update would take the count below zero. Correct operation never raises it.
- R10: An acknowledgment presented in the same cycle as a delivery is ignored, so the new map is exactly the reach bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_fire | input | 1 | The special line asserts this cycle |
| reach_map | input | N | Processors a delivery would reach |
| ack_vld | input | 1 | An acknowledgment arrives this cycle |
| ack_cpu | input | IDW | Index of the acknowledging processor |
| restore_start | input | 1 | Begin a full rebuild of the tracking state |
| pend_flags | input | N | Per-processor pending flags used during a restore |
| target_map | input | N | Processors the line's entry targets, used during a restore |
| delivered | output | 1 | Pulse: the firing was delivered |
| coalesced | output | 1 | Pulse: the firing was absorbed |
| dest_map | output | N | Processors still owing an acknowledgment |
| owed_cnt | output | CW | Number of outstanding acknowledgments |
| busy | output | 1 | A restore walk is in progress |
| done | output | 1 | Pulse: the restore walk finished |
| err | output | 1 | Sticky count-underflow flag |

## Verification
The bench delivers every possible reach bitmap of a four-processor configuration. It fires the line again before any acknowledgment to separate delivery from coalescing, then acknowledges each processor in turn, so that acknowledgments of owing and non-owing processors are told apart. A restore is run for every pairing of pending flags and target bitmaps. Each run starts from the leftover state of the previous one, which shows whether the wipe really happens. Firings and acknowledgments are injected mid-walk to show that they are ignored. An acknowledgment that coincides with a delivery separates the priority order of those two events.

// File: rtl/ack_trk_pkg.sv
package ack_trk_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_t;
endpackage

// File: rtl/atk_popcount.sv
module atk_popcount #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] ones_o
);
  logic [CW-1:0] partial [N+1];

  assign partial[0] = '0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_acc
      assign partial[g+1] = partial[g] + CW'(bits_i[g]);
    end
  endgenerate

  assign ones_o = partial[N];
endmodule

// File: rtl/atk_walker.sv
module atk_walker
  import ack_trk_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  output logic           wipe_o,
  output logic           visit_o,
  output logic [IDW-1:0] visit_idx_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam logic [IDW-1:0] LAST_IDX = IDW'(N - 1);

  walk_state_t    state_q;
  logic [IDW-1:0] idx_q;
  logic           done_q;

  assign wipe_o      = start_i && (state_q == WALK_IDLE);
  assign visit_o     = (state_q == WALK_RUN);
  assign visit_idx_o = idx_q;
  assign busy_o      = (state_q == WALK_RUN);
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        WALK_IDLE: begin
          if (start_i) begin
            state_q <= WALK_RUN;
            idx_q   <= '0;
          end
        end
        WALK_RUN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == WALK_IDLE)); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state_q == WALK_RUN) |-> (int'(idx_q) < N)); // R7
endmodule

// File: rtl/atk_ledger.sv
module atk_ledger #(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wipe_i,
  input  logic           visit_i,
  input  logic [IDW-1:0] visit_idx_i,
  input  logic           visit_tgt_i,
  input  logic           visit_pend_i,
  input  logic           load_i,
  input  logic [N-1:0]   load_map_i,
  input  logic [CW-1:0]  load_cnt_i,
  input  logic           ack_i,
  input  logic [IDW-1:0] ack_idx_i,
  output logic [N-1:0]   map_o,
  output logic [CW-1:0]  cnt_o,
  output logic           err_o
);
  logic [N-1:0]  map_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  logic ack_hit;
  logic visit_diff;

  assign ack_hit    = ack_i && (int'(ack_idx_i) < N) && map_q[ack_idx_i];
  assign visit_diff = visit_tgt_i && (visit_pend_i != map_q[visit_idx_i]);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (wipe_i) begin
      map_q <= '0;
      cnt_q <= '0;
    end else if (visit_i) begin
      if (visit_diff) begin
        map_q[visit_idx_i] <= visit_pend_i;
        if (visit_pend_i) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q == '0) begin
          err_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end else if (load_i) begin
      map_q <= load_map_i;
      cnt_q <= load_cnt_i;
    end else if (ack_hit) begin
      map_q[ack_idx_i] <= 1'b0;
      if (cnt_q == '0) begin
        err_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign map_o = map_q;
  assign cnt_o = cnt_q;
  assign err_o = err_q;

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) == $countones(map_q)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !err_q); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !wipe_i && !visit_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/ack_coalesce_tracker.sv
module ack_coalesce_tracker #(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_fire,
  input  logic [N-1:0]   reach_map,
  input  logic           ack_vld,
  input  logic [IDW-1:0] ack_cpu,
  input  logic           restore_start,
  input  logic [N-1:0]   pend_flags,
  input  logic [N-1:0]   target_map,
  output logic           delivered,
  output logic           coalesced,
  output logic [N-1:0]   dest_map,
  output logic [CW-1:0]  owed_cnt,
  output logic           busy,
  output logic           done,
  output logic           err
);
  logic           wipe;
  logic           visit;
  logic [IDW-1:0] visit_idx;
  logic           walk_busy;
  logic [CW-1:0]  reach_ones;
  logic           fire_ok;
  logic           deliver_now;
  logic           absorb_now;
  logic           ack_ok;
  logic           dlv_q;
  logic           coal_q;

  atk_walker #(.N(N), .IDW(IDW)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (restore_start),
    .wipe_o      (wipe),
    .visit_o     (visit),
    .visit_idx_o (visit_idx),
    .busy_o      (walk_busy),
    .done_o      (done)
  );

  atk_popcount #(.N(N), .CW(CW)) u_pop (
    .bits_i (reach_map),
    .ones_o (reach_ones)
  );

  assign fire_ok     = line_fire && !walk_busy && !wipe;
  assign deliver_now = fire_ok && (owed_cnt == '0);
  assign absorb_now  = fire_ok && (owed_cnt != '0);
  assign ack_ok      = ack_vld && !walk_busy && !wipe && !deliver_now;

  atk_ledger #(.N(N), .IDW(IDW), .CW(CW)) u_ledger (
    .clk          (clk),
    .rst          (rst),
    .wipe_i       (wipe),
    .visit_i      (visit),
    .visit_idx_i  (visit_idx),
    .visit_tgt_i  (target_map[visit_idx]),
    .visit_pend_i (pend_flags[visit_idx]),
    .load_i       (deliver_now),
    .load_map_i   (reach_map),
    .load_cnt_i   (reach_ones),
    .ack_i        (ack_ok),
    .ack_idx_i    (ack_cpu),
    .map_o        (dest_map),
    .cnt_o        (owed_cnt),
    .err_o        (err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_q  <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      dlv_q  <= deliver_now;
      coal_q <= absorb_now;
    end
  end

  assign delivered = dlv_q;
  assign coalesced = coal_q;
  assign busy      = walk_busy;

  AST_DELIVER_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (line_fire && !walk_busy && !restore_start && owed_cnt == '0) |=> delivered); // R2
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(delivered && coalesced)); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    walk_busy |=> (!delivered && !coalesced)); // R8
  AST_HOLD_WHILE_OWED: assert property (@(posedge clk) disable iff (rst)
    (owed_cnt != '0 && !walk_busy && !restore_start && !ack_vld) |=> $stable(dest_map)); // R3
endmodule

// File: tb/sim_ack_coalesce_tracker.sv
module sim_ack_coalesce_tracker;
  localparam int N   = 4;
  localparam int IDW = 2;
  localparam int CW  = 3;

  logic           clk = 1'b0;
  logic           rst;
  logic           line_fire;
  logic [N-1:0]   reach_map;
  logic           ack_vld;
  logic [IDW-1:0] ack_cpu;
  logic           restore_start;
  logic [N-1:0]   pend_flags;
  logic [N-1:0]   target_map;
  logic           delivered;
  logic           coalesced;
  logic [N-1:0]   dest_map;
  logic [CW-1:0]  owed_cnt;
  logic           busy;
  logic           done;
  logic           err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ack_coalesce_tracker #(.N(N), .IDW(IDW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .line_fire(line_fire), .reach_map(reach_map),
    .ack_vld(ack_vld), .ack_cpu(ack_cpu), .restore_start(restore_start),
    .pend_flags(pend_flags), .target_map(target_map), .delivered(delivered),
    .coalesced(coalesced), .dest_map(dest_map), .owed_cnt(owed_cnt),
    .busy(busy), .done(done), .err(err)
  );

  function automatic int ones(input logic [N-1:0] v);
    int s = 0;
    for (int i = 0; i < N; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_state(input string tag, input logic [N-1:0] em);
    chk({tag, " map"}, int'(dest_map), int'(em));
    chk({tag, " cnt"}, int'(owed_cnt), ones(em));
    chk("R6 count equals map population", int'(owed_cnt), ones(dest_map));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] exp_map;
    rst = 1'b1; line_fire = 0; reach_map = 0; ack_vld = 0; ack_cpu = 0;
    restore_start = 0; pend_flags = 0; target_map = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 map", int'(dest_map), 0);
    chk("R1 cnt", int'(owed_cnt), 0);
    chk("R1 delivered", int'(delivered), 0);
    chk("R1 coalesced", int'(coalesced), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);

    // Sweep every reach bitmap
    for (int m = 0; m < 16; m++) begin
      line_fire = 1; reach_map = 4'(m);
      tick();
      line_fire = 0;
      exp_map = 4'(m);
      chk("R2 delivered", int'(delivered), 1);
      chk("R2 no coalesce", int'(coalesced), 0);
      chk_state("R2", exp_map);
      if (m != 0) begin
        line_fire = 1; reach_map = ~4'(m);
        tick();
        line_fire = 0;
        chk("R3 coalesced", int'(coalesced), 1);
        chk("R3 no delivery", int'(delivered), 0);
        chk_state("R3 unchanged", exp_map);
      end
      for (int c = 0; c < N; c++) begin
        logic had;
        had = exp_map[c];
        ack_vld = 1; ack_cpu = 2'(c);
        tick();
        ack_vld = 0;
        exp_map[c] = 1'b0;
        chk_state(had ? "R4 ack owing" : "R5 ack non-owing", exp_map);
      end
    end

    // R10 ack coincident with delivery
    line_fire = 1; reach_map = 4'b0011; ack_vld = 1; ack_cpu = 2'd0;
    tick();
    line_fire = 0; ack_vld = 0;
    chk("R10 delivered", int'(delivered), 1);
    chk_state("R10", 4'b0011);

    // Restore sweep: leftover state from previous step must be wiped
    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 16; t++) begin
        pend_flags = 4'(p); target_map = 4'(t);
        restore_start = 1;
        tick();
        restore_start = 0;
        chk("R7 busy", int'(busy), 1);
        chk_state("R7 wipe", 4'b0000);
        line_fire = 1; reach_map = 4'b1111; ack_vld = 1; ack_cpu = 2'd0;
        restore_start = 1;
        tick();
        chk("R8 no delivery", int'(delivered), 0);
        chk("R8 no coalesce", int'(coalesced), 0);
        tick();
        line_fire = 0; ack_vld = 0; restore_start = 0;
        chk("R8 no delivery", int'(delivered), 0);
        chk("R8 no coalesce", int'(coalesced), 0);
        chk("R7 done early", int'(done), 0);
        tick(); tick();
        chk("R7 done", int'(done), 1);
        chk("R7 busy low", int'(busy), 0);
        chk_state("R7 rebuilt", 4'(p) & 4'(t));
        tick();
        chk("R7 done pulse", int'(done), 0);
      end
    end

    chk("R9 err", int'(err), 0);
    finish_run();
  end
endmodule